// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer whose depth is a power-of-two parameter from 256 to 4096 words. Words enter on a write clock with a write enable. They leave on a read clock with a read enable. The two clocks can be one shared net, or they can run with no fixed relation to each other. Both pointers cross between the clock domains as Gray code through two-flop synchronizers. Full, Almost-Full and Half-Full are computed in the write domain. Empty and Almost-Empty are computed in the read domain.

The two threshold offsets take default values at reset. They can be changed at run time. While the load strobe is high, each write-enabled cycle stores the low address bits of the data input into one offset register. The first such cycle loads the near-empty offset and the second loads the near-full offset. A further cycle wraps back to the near-empty offset. Dropping the strobe rewinds the selection. The read data is registered, and an output enable either drives that register onto the output or releases the output to high impedance.

Top module: `dcfifo_pflag`

## Requirements
- R1: While reset is held and after it is released, with nothing written: empty=1, almost_empty=1, half_full=0, almost_full=0, full=0, and dout=0 while oe=1.
- R2: Words are returned in the order they were written, with all 18 bits intact. A read taken on a rising rclk edge shows its word on dout right after that edge.
- R3: A write while full is high is dropped. It moves no pointer, changes no stored word, and later reads return the earlier contents.
- R4: A read while empty is high is dropped. dout keeps its previous value and the read pointer does not move.
- R5: full is 1 exactly when the fill level equals the depth. It rises right after the write edge that fills the last slot.
- R6: With rclk tied to wclk, a word written into an empty buffer on edge E0 keeps empty at 1 after edges E0 and E1, and empty falls after edge E2.
- R7: almost_empty is 1 exactly when the settled fill level is at or below the near-empty offset. That offset defaults to the parameter AE_DEF, which is 7.
- R8: almost_full is 1 exactly when the free space (depth minus fill level) is at or below the near-full offset. That offset defaults to the parameter AF_DEF, which is 7.
- R9: half_full is 1 exactly when the fill level is strictly greater than half the depth.
- R10: While ld=1, each cycle with wr_en=1 stores din[AW-1:0] as an offset and stores nothing in the buffer. The first cycle sets the near-empty offset, the second sets the near-full offset, and a third wraps back to near-empty. Releasing ld rewinds this order to near-empty.
- R11: With oe=0, dout is not driven (high impedance). Returning oe to 1 shows the held read word again.
- R12: With wclk and rclk unrelated, and with reads and writes overlapping, every word comes out once and in order, and each domain's Gray pointer changes at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released separately in each domain |
| wr_en | input | 1 | Write enable; loads an offset instead while ld is high |
| ld | input | 1 | Offset-load strobe (write domain) |
| din | input | 18 | Write data, or an offset value in its low AW bits |
| rd_en | input | 1 | Read enable |
| oe | input | 1 | Output enable; 0 releases dout to high impedance |
| dout | output | 18 | Registered read data |
| empty | output | 1 | No word available to read |
| full | output | 1 | No free slot |
| almost_empty | output | 1 | Fill level at or below the near-empty offset |
| almost_full | output | 1 | Free space at or below the near-full offset |
| half_full | output | 1 | Fill level above half the depth |

## Verification
The assertions check on every cycle that each domain's fill estimate never goes past the depth. They also check that full always implies almost_full and empty always implies almost_empty, that the Gray pointers step by at most one bit, that the offset selector rewinds when the strobe drops, and that a read into an empty buffer leaves the output register unchanged. Other behaviour can only be shown by the bench's scenarios. This covers the exact threshold boundaries for default and reloaded offsets, the two-edge empty latency on a shared clock, dropped writes that would otherwise overwrite the oldest word, data order under overlapping traffic on unrelated clocks, and the high-impedance output.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W = 18;

  // offset register selected by the load sequencer
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;

  function automatic logic [31:0] gray_enc(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_dec(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s0, s1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      s0 <= 1'b1;
      s1 <= s0;
    end
  end

  assign rst_n_o = s1;
endmodule

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          ld,
  input  logic [AW-1:0] ofs_din,
  input  logic [PW-1:0] rgray_s,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] ae_ofs,
  output logic          full,
  output logic          almost_full,
  output logic          half_full
);
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_V  = PW'(DEPTH / 2);

  logic [PW-1:0] wbin, wbin_nx, rbin_s, wcnt;
  logic [AW-1:0] ae_q, af_q, ae_nx, af_nx;
  ofs_sel_e      sel, sel_nx;
  logic          ld_fire;

  // next-state
  always_comb begin
    ld_fire = wr_en & ld;
    wr_fire = wr_en & ~ld & ~full;
    wbin_nx = wbin + PW'(1);
    ae_nx   = ae_q;
    af_nx   = af_q;
    if (ld_fire) begin
      if (sel == SEL_AE) ae_nx = ofs_din;
      else               af_nx = ofs_din;
    end
    sel_nx = sel;
    if (!ld)          sel_nx = SEL_AE;
    else if (ld_fire) sel_nx = (sel == SEL_AE) ? SEL_AF : SEL_AE;
  end

  // write-domain flags
  always_comb begin
    rbin_s      = PW'(gray_dec(32'(rgray_s)));
    wcnt        = wbin - rbin_s;
    full        = (wcnt == DEPTH_V);
    almost_full = ((DEPTH_V - wcnt) <= {1'b0, af_q});
    half_full   = (wcnt > HALF_V);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      sel   <= SEL_AE;
      ae_q  <= AW'(AE_DEF);
      af_q  <= AW'(AF_DEF);
    end else begin
      if (wr_fire) begin
        wbin  <= wbin_nx;
        wgray <= PW'(gray_enc(32'(wbin_nx)));
      end
      if (ld_fire) begin
        ae_q <= ae_nx;
        af_q <= af_nx;
      end
      sel <= sel_nx;
    end
  end

  assign waddr  = wbin[AW-1:0];
  assign ae_ofs = ae_q;

  p_wcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= DEPTH_V);
  p_full_near_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> almost_full);
  p_wgray_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  p_ld_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (sel == SEL_AE));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  input  logic [AW-1:0] ae_ofs,
  output logic          rd_fire,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          almost_empty
);
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  logic [PW-1:0] rbin, rbin_nx, wbin_s, rcnt;

  always_comb begin
    wbin_s       = PW'(gray_dec(32'(wgray_s)));
    rcnt         = wbin_s - rbin;
    empty        = (rcnt == '0);
    almost_empty = (rcnt <= {1'b0, ae_ofs});
    rd_fire      = rd_en & ~empty;
    rbin_nx      = rbin + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_fire) begin
      rbin  <= rbin_nx;
      rgray <= PW'(gray_enc(32'(rbin_nx)));
    end
  end

  assign raddr = rbin[AW-1:0];

  p_rcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= DEPTH_V);
  p_empty_near_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> almost_empty);
  p_rgray_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en,
  input  logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              half_full
);
  logic              wrst_n, rrst_n;
  logic              wr_fire, rd_fire;
  logic [AW-1:0]     waddr, raddr, ae_ofs;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  dcf_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .rst_n_o(wrst_n));
  dcf_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .rst_n_o(rrst_n));

  dcf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  dcf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  dcf_wr_ctl #(.DEPTH(DEPTH), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .wr_en(wr_en), .ld(ld), .ofs_din(din[AW-1:0]),
    .rgray_s(rgray_s), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .ae_ofs(ae_ofs), .full(full), .almost_full(almost_full), .half_full(half_full)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s), .ae_ofs(ae_ofs),
    .rd_fire(rd_fire), .raddr(raddr), .rgray(rgray), .empty(empty),
    .almost_empty(almost_empty)
  );

  // storage array, write port
  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= din;
  end

  // registered read port
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)      rdata_q <= '0;
    else if (rd_fire) rdata_q <= mem[raddr];
  end

  assign dout = oe ? rdata_q : 'z;

  p_empty_rd_hold_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (empty && rd_en) |=> $stable(rdata_q));
endmodule

// File: tb/dcfifo_pflag_test.sv
module dcfifo_pflag_test;
  localparam int DEPTH = 256;

  logic clk = 1'b0, clk2 = 1'b0, sep = 1'b0;
  logic rclk;
  always #4 clk = ~clk;          // 125 MHz
  always #5.5 clk2 = ~clk2;      // unrelated read clock
  assign rclk = sep ? clk2 : clk;

  logic rst_n, wr_en, ld, rd_en, oe;
  logic [17:0] din, dout;
  logic empty, full, almost_empty, almost_full, half_full;

  dcfifo_pflag #(.DEPTH(DEPTH)) uut (
    .wclk(clk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .ld(ld), .din(din),
    .rd_en(rd_en), .oe(oe), .dout(dout), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full), .half_full(half_full)
  );

  int checks = 0, bad = 0, seq = 0, mae = 7, maf = 7;
  logic [17:0] mq[$];
  logic [17:0] last_dout = '0;

  // {is_write, count, expected {empty, almost_empty, half_full, almost_full, full}}
  localparam logic [14:0] VEC [14] = '{
    {1'b1, 9'd1,   5'b01000}, {1'b1, 9'd6,   5'b01000}, {1'b1, 9'd1,   5'b00000},
    {1'b1, 9'd120, 5'b00000}, {1'b1, 9'd1,   5'b00100}, {1'b1, 9'd119, 5'b00100},
    {1'b1, 9'd1,   5'b00110}, {1'b1, 9'd7,   5'b00111}, {1'b1, 9'd3,   5'b00111},
    {1'b0, 9'd1,   5'b00110}, {1'b0, 9'd127, 5'b00000}, {1'b0, 9'd121, 5'b01000},
    {1'b0, 9'd7,   5'b11000}, {1'b0, 9'd2,   5'b11000}
  };

  function automatic logic [17:0] pat(input int s);
    return 18'((s * 1103) ^ 18'h2b5c7);
  endfunction

  function automatic logic [4:0] exp_fl(input int c);
    return {c == 0, c <= mae, c > DEPTH / 2, (DEPTH - c) <= maf, c == DEPTH};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] flags();
    return {empty, almost_empty, half_full, almost_full, full};
  endfunction

  task automatic wr_n(input int n);
    @(negedge clk);
    din = pat(seq);
    wr_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (mq.size() < DEPTH) mq.push_back(din);
      seq++;
      @(negedge clk);
      if (i < n - 1) din = pat(seq);
      else wr_en = 1'b0;
    end
  endtask

  task automatic rd_n(input int n);
    logic [17:0] e;
    @(negedge rclk);
    rd_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge rclk);
      e = (mq.size() > 0) ? mq.pop_front() : last_dout;
      @(negedge rclk);
      chk(dout == e, "R2 R3 R4 read data", 32'(dout), 32'(e));
      last_dout = e;
      if (i == n - 1) rd_en = 1'b0;
    end
  endtask

  task automatic load_ofs(input int n, input logic [17:0] v0, input logic [17:0] v1,
                          input logic [17:0] v2);
    logic sel;
    sel = 1'b0;
    @(negedge clk);
    ld = 1'b1;
    wr_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      din = (i == 0) ? v0 : (i == 1) ? v1 : v2;
      @(posedge clk);
      if (!sel) mae = int'(din[7:0]);
      else      maf = int'(din[7:0]);
      sel = ~sel;
      @(negedge clk);
    end
    wr_en = 1'b0;
    ld = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic chk_flags(input string tag);
    settle();
    chk(flags() == exp_fl(mq.size()), tag, 32'(flags()), 32'(exp_fl(mq.size())));
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; ld = 1'b0; rd_en = 1'b0; oe = 1'b1; din = '0;
    repeat (3) @(negedge clk);
    chk(flags() == 5'b11000, "R1 flags in reset", 32'(flags()), 32'h18);
    chk(dout == '0, "R1 dout in reset", 32'(dout), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(flags() == 5'b11000, "R1 flags after reset", 32'(flags()), 32'h18);
    chk(dout == '0, "R1 dout after reset", 32'(dout), 0);

    // R6: empty latency with tied clocks
    din = pat(seq);
    wr_en = 1'b1;
    @(posedge clk);
    mq.push_back(din);
    seq++;
    @(negedge clk);
    wr_en = 1'b0;
    chk(empty == 1'b1, "R6 empty after E0", 32'(empty), 1);
    @(negedge clk);
    chk(empty == 1'b1, "R6 empty after E1", 32'(empty), 1);
    @(negedge clk);
    chk(empty == 1'b0, "R6 empty after E2", 32'(empty), 0);
    rd_n(1);
    settle();

    // table: R5 R7 R8 R9 thresholds, R3 dropped writes, R4 dropped reads
    for (int v = 0; v < 14; v++) begin
      if (VEC[v][14]) wr_n(int'(VEC[v][13:5]));
      else            rd_n(int'(VEC[v][13:5]));
      settle();
      chk(flags() == VEC[v][4:0], "R5 R7 R8 R9 table flags", 32'(flags()),
          32'(VEC[v][4:0]));
    end

    // R11: output released
    @(negedge clk);
    oe = 1'b0;
    #1;
    chk((dout === 18'h0) || (dout === 18'hz), "R11 dout undriven", 32'(dout), 0);
    oe = 1'b1;
    #1;
    chk(dout == last_dout, "R11 dout back", 32'(dout), 32'(last_dout));

    // R10: load offsets 20 / 30, buffer untouched
    load_ofs(2, 18'h3f014, 18'h2201e, '0);
    chk_flags("R10 load leaves buffer empty");
    wr_n(20);  chk_flags("R7 R10 at near-empty offset 20");
    wr_n(1);   chk_flags("R7 R10 above near-empty offset");
    wr_n(204); chk_flags("R8 R10 free space 31");
    wr_n(1);   chk_flags("R8 R10 free space 30");
    rd_n(226); chk_flags("R2 drained");

    // R10: three writes in one strobe wrap to near-empty: ae=5, af=40
    load_ofs(3, 18'h00009, 18'h00028, 18'h00005);
    wr_n(5);   chk_flags("R7 R10 wrapped offset 5");
    wr_n(1);   chk_flags("R7 R10 above wrapped offset");
    wr_n(209); chk_flags("R8 R10 free space 41");
    wr_n(1);   chk_flags("R8 R10 free space 40");
    rd_n(216); chk_flags("R2 drained again");

    // R12: unrelated clocks with overlapping traffic
    sep = 1'b1;
    settle();
    fork
      wr_n(60);
      begin
        repeat (10) @(negedge clk);
        rd_n(30);
      end
    join
    settle();
    rd_n(30);
    chk_flags("R12 empty after cross-clock drain");
    chk(mq.size() == 0, "R12 model drained", 32'(mq.size()), 0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule